// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit data pointers for an 8051-class core together with an 8-bit control register that picks which pointer is active. The core's decoder hands it one operation code per cycle: load an immediate, step, table read, external read, external write or indirect jump. Each pointer byte and the control register can also be read, written or given a direct-address increment through the special-function-register path.

The block drives the address that the operation needs. For a table read this is the active pointer plus the accumulator, cut to the program-memory width. For an indirect jump it is the same sum taken modulo 2^16. Every other operation gets the active pointer unchanged. A step moves the active pointer up or down by one, in the direction set for that pointer. When auto-switching is enabled, the selector flips after each pointer operation except the jump.

Top module: `dual_ptr_unit`

## Requirements
- R1: A synchronous active-high reset clears both pointers and the control register. After reset pointer 0 is selected, both pointers count up and auto-switching is off.
- R2: Register addresses are 0x82 (pointer 0 low), 0x83 (pointer 0 high), 0x84 (pointer 1 low), 0x85 (pointer 1 high) and 0x86 (control). A write stores the byte. A read of those addresses returns the stored byte, and a read of any other address returns 0.
- R3: Control bit 0 selects the active pointer (0 selects pointer 0, 1 selects pointer 1), and `ptr_active` shows the selected pointer.
- R4: Op code 1 (load) writes `imm_hi` to the high byte and `imm_lo` to the low byte of the active pointer. The other pointer is left unchanged.
- R5: Op code 2 (step) adds 1 to the active pointer, or subtracts 1 when its direction bit is set (control bit 6 for pointer 0, bit 7 for pointer 1). The result wraps modulo 2^16, with carry or borrow between the bytes.
- R6: With control bit 5 set, control bit 0 flips at the end of op codes 1 to 5.
- R7: Op code 6 (jump) drives `addr_out` = active pointer + `acc` modulo 2^16, and it never flips the selector.
- R8: Op code 3 (table read) drives `addr_out` = (active pointer + `acc`), keeping only the low `PROG_AW` bits.
- R9: Op codes 4 and 5 (external read and write) and op codes 0 and 7 drive `addr_out` equal to the active pointer. Only a step or a load changes a pointer.
- R10: A direct increment aimed at 0x86 flips only control bit 0. Aimed at any pointer byte, it adds 1 to that byte alone, modulo 256.
- R11: When a register write or a direct increment occurs in the same cycle as an operation, the register access takes effect and the operation changes neither pointer nor selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Decoded pointer operation (0 none, 1 load, 2 step, 3 table, 4 ext read, 5 ext write, 6 jump) |
| imm_hi | input | 8 | First fetched immediate byte (high half) |
| imm_lo | input | 8 | Second fetched immediate byte (low half) |
| acc | input | 8 | Accumulator value |
| reg_wr_en | input | 1 | Register write strobe |
| reg_inc_en | input | 1 | Direct-address increment strobe |
| reg_addr | input | 8 | Register address for write or increment |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 8 | Register read address |
| reg_rd_data | output | 8 | Register read data (combinational) |
| ptr_active | output | 16 | Currently selected pointer |
| addr_out | output | 16 | Memory or jump address for the current operation |

## Verification
The step operation is driven with values that sit on the byte boundary and on the 16-bit wrap in both directions. The direction bits are set crosswise so that each pointer is stepped while only the other pointer's bit is set, which shows whether the correct bit is read. The address path uses sums that overflow 16 bits and sums that go past the program-memory width, which separates the jump's plain wrap from the table read's mask. Auto-switching runs through all six operations in turn, and a lone non-toggle reveals the one that is exempt. Operations issued together with a register access show whether the access takes priority.

// File: rtl/dual_ptr_pkg.sv
package dual_ptr_pkg;

    localparam int PTR_W   = 16;
    localparam int NUM_PTR = 2;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STEP  = 3'd2,
        OP_TABLE = 3'd3,
        OP_XRD   = 3'd4,
        OP_XWR   = 3'd5,
        OP_JUMP  = 3'd6,
        OP_RSVD  = 3'd7
    } ptr_op_e;

    // Control register layout, MSB first
    typedef struct packed {
        logic       dir1;     // bit 7: pointer 1 counts down
        logic       dir0;     // bit 6: pointer 0 counts down
        logic       auto_sw;  // bit 5: flip selector after pointer ops
        logic [3:0] spare;    // bits 4..1: stored only
        logic       sel;      // bit 0: active pointer
    } ctrl_t;

    function automatic logic op_flips_sel(input ptr_op_e op);
        return (op == OP_LOAD) || (op == OP_STEP) || (op == OP_TABLE) ||
               (op == OP_XRD)  || (op == OP_XWR);
    endfunction

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] v,
                                                  input logic down);
        return down ? (v - PTR_W'(1)) : (v + PTR_W'(1));
    endfunction

endpackage

// File: rtl/dual_ptr_reg.sv
module dual_ptr_reg
    import dual_ptr_pkg::*;
#(
    parameter logic [7:0] ADDR_LO = 8'h82,
    parameter logic [7:0] ADDR_HI = 8'h83
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic             reg_inc_en,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wr_data,
    input  logic             load_en,
    input  logic             step_en,
    input  logic             down,
    input  logic [PTR_W-1:0] imm,
    output logic [PTR_W-1:0] val_q
);

    logic hit_lo, hit_hi;
    assign hit_lo = (reg_addr == ADDR_LO);
    assign hit_hi = (reg_addr == ADDR_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (reg_wr_en) begin
            if (hit_lo) val_q[7:0]  <= reg_wr_data;
            if (hit_hi) val_q[15:8] <= reg_wr_data;
        end else if (reg_inc_en) begin
            if (hit_lo) val_q[7:0]  <= val_q[7:0] + 8'd1;
            if (hit_hi) val_q[15:8] <= val_q[15:8] + 8'd1;
        end else if (load_en) begin
            val_q <= imm;
        end else if (step_en) begin
            val_q <= step_ptr(val_q, down);
        end
    end

endmodule

// File: rtl/dual_ptr_ctrl.sv
module dual_ptr_ctrl
    import dual_ptr_pkg::*;
#(
    parameter logic [7:0] ADDR_CTRL = 8'h86
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr_en,
    input  logic       reg_inc_en,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wr_data,
    input  logic       op_go,
    input  ptr_op_e    op,
    output ctrl_t      ctrl_q
);

    logic hit;
    assign hit = (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_wr_en) begin
            if (hit) ctrl_q <= ctrl_t'(reg_wr_data);
        end else if (reg_inc_en) begin
            if (hit) ctrl_q.sel <= ~ctrl_q.sel;
        end else if (op_go && ctrl_q.auto_sw && op_flips_sel(op)) begin
            ctrl_q.sel <= ~ctrl_q.sel;
        end
    end

endmodule

// File: rtl/dual_ptr_addr.sv
module dual_ptr_addr
    import dual_ptr_pkg::*;
#(
    parameter int PROG_AW = 16
) (
    input  ptr_op_e          op,
    input  logic [PTR_W-1:0] ptr,
    input  logic [7:0]       acc,
    output logic [PTR_W-1:0] addr
);

    localparam logic [PTR_W-1:0] PROG_MASK =
        PTR_W'((33'd1 << PROG_AW) - 33'd1);

    logic [PTR_W-1:0] sum;
    assign sum = ptr + {8'd0, acc};

    always_comb begin
        unique case (op)
            OP_TABLE: addr = sum & PROG_MASK;
            OP_JUMP:  addr = sum;
            default:  addr = ptr;
        endcase
    end

endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
    import dual_ptr_pkg::*;
#(
    parameter int         PROG_AW    = 16,
    parameter logic [7:0] ADDR_P0_LO = 8'h82,
    parameter logic [7:0] ADDR_P0_HI = 8'h83,
    parameter logic [7:0] ADDR_P1_LO = 8'h84,
    parameter logic [7:0] ADDR_P1_HI = 8'h85,
    parameter logic [7:0] ADDR_CTRL  = 8'h86
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_code,
    input  logic [7:0]  imm_hi,
    input  logic [7:0]  imm_lo,
    input  logic [7:0]  acc,
    input  logic        reg_wr_en,
    input  logic        reg_inc_en,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wr_data,
    input  logic [7:0]  reg_rd_addr,
    output logic [7:0]  reg_rd_data,
    output logic [15:0] ptr_active,
    output logic [15:0] addr_out
);

    ptr_op_e          op;
    logic             op_go;
    ctrl_t            ctrl_q;
    logic [PTR_W-1:0] ptr_q [NUM_PTR];
    logic             sel_now;
    logic             auto_now;
    logic             dir_now;

    assign op       = ptr_op_e'(op_code);
    assign op_go    = !(reg_wr_en || reg_inc_en);
    assign sel_now  = ctrl_q.sel;
    assign auto_now = ctrl_q.auto_sw;
    assign dir_now  = ctrl_q.sel ? ctrl_q.dir1 : ctrl_q.dir0;

    dual_ptr_ctrl #(.ADDR_CTRL(ADDR_CTRL)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_inc_en  (reg_inc_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .op_go       (op_go),
        .op          (op),
        .ctrl_q      (ctrl_q)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        localparam logic [7:0] A_LO = (g == 0) ? ADDR_P0_LO : ADDR_P1_LO;
        localparam logic [7:0] A_HI = (g == 0) ? ADDR_P0_HI : ADDR_P1_HI;
        logic mine;
        logic down;
        assign mine = op_go && (ctrl_q.sel == 1'(g));
        assign down = (g == 0) ? ctrl_q.dir0 : ctrl_q.dir1;

        dual_ptr_reg #(.ADDR_LO(A_LO), .ADDR_HI(A_HI)) u_reg (
            .clk         (clk),
            .rst         (rst),
            .reg_wr_en   (reg_wr_en),
            .reg_inc_en  (reg_inc_en),
            .reg_addr    (reg_addr),
            .reg_wr_data (reg_wr_data),
            .load_en     (mine && (op == OP_LOAD)),
            .step_en     (mine && (op == OP_STEP)),
            .down        (down),
            .imm         ({imm_hi, imm_lo}),
            .val_q       (ptr_q[g])
        );
    end

    assign ptr_active = ptr_q[ctrl_q.sel];

    dual_ptr_addr #(.PROG_AW(PROG_AW)) u_addr (
        .op   (op),
        .ptr  (ptr_active),
        .acc  (acc),
        .addr (addr_out)
    );

    always_comb begin
        if      (reg_rd_addr == ADDR_P0_LO) reg_rd_data = ptr_q[0][7:0];
        else if (reg_rd_addr == ADDR_P0_HI) reg_rd_data = ptr_q[0][15:8];
        else if (reg_rd_addr == ADDR_P1_LO) reg_rd_data = ptr_q[1][7:0];
        else if (reg_rd_addr == ADDR_P1_HI) reg_rd_data = ptr_q[1][15:8];
        else if (reg_rd_addr == ADDR_CTRL)  reg_rd_data = ctrl_q;
        else                                reg_rd_data = 8'd0;
    end

endmodule

// File: rtl/dual_ptr_checker.sv
module dual_ptr_checker #(
    parameter int         PROG_AW   = 16,
    parameter logic [7:0] ADDR_CTRL = 8'h86
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_code,
    input logic        reg_wr_en,
    input logic        reg_inc_en,
    input logic [7:0]  reg_addr,
    input logic [15:0] ptr_active,
    input logic [15:0] addr_out,
    input logic        sel_now,
    input logic        auto_now,
    input logic        dir_now
);

    logic quiet;
    assign quiet = !reg_wr_en && !reg_inc_en;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ptr_active == 16'd0 && !sel_now && !auto_now)); // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (quiet && op_code == 3'd2 && !auto_now && !dir_now)
        |=> ptr_active == $past(ptr_active) + 16'd1); // R5

    AST_AUTO_FLIP: assert property (@(posedge clk) disable iff (rst)
        (quiet && auto_now && op_code >= 3'd1 && op_code <= 3'd5)
        |=> sel_now != $past(sel_now)); // R6

    AST_JUMP_HOLDS_SEL: assert property (@(posedge clk) disable iff (rst)
        (quiet && op_code == 3'd6) |=> $stable(sel_now)); // R7

    AST_TABLE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd3) |-> (PROG_AW >= 16 || (32'(addr_out) >> PROG_AW) == 0)); // R8

    AST_XFER_ADDR: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd4 || op_code == 3'd5) |-> addr_out == ptr_active); // R9

    AST_CTRL_BUMP: assert property (@(posedge clk) disable iff (rst)
        (reg_inc_en && !reg_wr_en && reg_addr == ADDR_CTRL)
        |=> (sel_now != $past(sel_now) && auto_now == $past(auto_now))); // R10

    AST_ACCESS_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 8'h00 && op_code != 3'd0)
        |=> ($stable(ptr_active) && $stable(sel_now))); // R11

endmodule

bind dual_ptr_unit dual_ptr_checker #(
    .PROG_AW   (PROG_AW),
    .ADDR_CTRL (ADDR_CTRL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_code    (op_code),
    .reg_wr_en  (reg_wr_en),
    .reg_inc_en (reg_inc_en),
    .reg_addr   (reg_addr),
    .ptr_active (ptr_active),
    .addr_out   (addr_out),
    .sel_now    (sel_now),
    .auto_now   (auto_now),
    .dir_now    (dir_now)
);

// File: tb/dual_ptr_unit_test.sv
`timescale 1ns/1ps
module dual_ptr_unit_test;

    localparam int TB_PROG_AW = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  imm_hi = 8'd0, imm_lo = 8'd0, acc = 8'd0;
    logic        reg_wr_en = 1'b0, reg_inc_en = 1'b0;
    logic [7:0]  reg_addr = 8'd0, reg_wr_data = 8'd0, reg_rd_addr = 8'd0;
    logic [7:0]  reg_rd_data;
    logic [15:0] ptr_active, addr_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dual_ptr_unit #(.PROG_AW(TB_PROG_AW)) uut (
        .clk(clk), .rst(rst), .op_code(op_code), .imm_hi(imm_hi),
        .imm_lo(imm_lo), .acc(acc), .reg_wr_en(reg_wr_en),
        .reg_inc_en(reg_inc_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .ptr_active(ptr_active),
        .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = 8'd0;
    endtask

    task automatic reg_bump(input logic [7:0] a);
        @(negedge clk);
        reg_inc_en = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_inc_en = 1'b0; reg_addr = 8'd0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    // Issue one op; optional simultaneous register write/increment to addr a.
    task automatic run_op(input logic [2:0] code, input logic [15:0] imm,
                          input logic [7:0] acc_v, input logic wr,
                          input logic inc, input logic [7:0] a,
                          output logic [15:0] seen);
        @(negedge clk);
        op_code = code; imm_hi = imm[15:8]; imm_lo = imm[7:0]; acc = acc_v;
        reg_wr_en = wr; reg_inc_en = inc; reg_addr = a; reg_wr_data = 8'd0;
        #1 seen = addr_out;
        @(posedge clk); #1;
        op_code = 3'd0; reg_wr_en = 1'b0; reg_inc_en = 1'b0; reg_addr = 8'd0;
    endtask

    task automatic set_ptr(input int idx, input logic [15:0] v);
        reg_write(idx == 0 ? 8'h82 : 8'h84, v[7:0]);
        reg_write(idx == 0 ? 8'h83 : 8'h85, v[15:8]);
    endtask

    task automatic sample_ptr(input string req, input logic [15:0] exp);
        @(negedge clk);
        #1 check(req, ptr_active, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        sample_ptr("R1 ptr after reset", 16'h0000);
        for (int a = 8'h82; a <= 8'h86; a++) begin
            read_reg(8'(a), d);
            check("R1 reg after reset", {8'd0, d}, 16'h0000);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        set_ptr(0, 16'h1234);
        set_ptr(1, 16'habcd);
        read_reg(8'h82, d); check("R2 p0 lo", {8'd0, d}, 16'h0034);
        read_reg(8'h83, d); check("R2 p0 hi", {8'd0, d}, 16'h0012);
        read_reg(8'h84, d); check("R2 p1 lo", {8'd0, d}, 16'h00cd);
        read_reg(8'h85, d); check("R2 p1 hi", {8'd0, d}, 16'h00ab);
        reg_write(8'h90, 8'h5a);
        read_reg(8'h90, d); check("R2 foreign addr reads 0", {8'd0, d}, 16'h0000);
        sample_ptr("R3 sel 0", 16'h1234);
        reg_write(8'h86, 8'h1e);
        read_reg(8'h86, d); check("R2 ctrl readback", {8'd0, d}, 16'h001e);
        sample_ptr("R3 sel 0 spare bits set", 16'h1234);
        reg_write(8'h86, 8'h01);
        sample_ptr("R3 sel 1", 16'habcd);
    endtask

    task automatic t_load();
        logic [15:0] s;
        logic [7:0]  d;
        run_op(3'd1, 16'h5566, 8'h00, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h85, d); check("R4 load high byte", {8'd0, d}, 16'h0055);
        read_reg(8'h84, d); check("R4 load low byte", {8'd0, d}, 16'h0066);
        read_reg(8'h83, d); check("R4 other ptr hi kept", {8'd0, d}, 16'h0012);
        read_reg(8'h82, d); check("R4 other ptr lo kept", {8'd0, d}, 16'h0034);
    endtask

    task automatic t_step();
        logic [15:0] s;
        reg_write(8'h86, 8'h00);
        set_ptr(0, 16'h12ff);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 up with carry", 16'h1300);
        reg_write(8'h86, 8'h40);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 down with borrow", 16'h12ff);
        set_ptr(0, 16'h0000);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 down wraps", 16'hffff);
        set_ptr(1, 16'hffff);
        reg_write(8'h86, 8'h41);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 p1 ignores bit 6, wraps up", 16'h0000);
        reg_write(8'h86, 8'h81);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 p1 bit 7 counts down", 16'hffff);
        reg_write(8'h86, 8'h80);
        set_ptr(0, 16'h0010);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        sample_ptr("R5 p0 ignores bit 7", 16'h0011);
        reg_write(8'h86, 8'h00);
    endtask

    task automatic t_auto();
        logic [15:0] s;
        logic [7:0]  d;
        reg_write(8'h86, 8'h20);
        run_op(3'd1, 16'h0100, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R6 flip after load", {8'd0, d}, 16'h0021);
        run_op(3'd2, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R6 flip after step", {8'd0, d}, 16'h0020);
        run_op(3'd3, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R6 flip after table", {8'd0, d}, 16'h0021);
        run_op(3'd4, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R6 flip after ext read", {8'd0, d}, 16'h0020);
        run_op(3'd5, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R6 flip after ext write", {8'd0, d}, 16'h0021);
        run_op(3'd6, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00, s);
        read_reg(8'h86, d); check("R7 jump does not flip", {8'd0, d}, 16'h0021);
        reg_write(8'h86, 8'h00);
    endtask

    task automatic t_addr();
        logic [15:0] s;
        set_ptr(0, 16'hfff0);
        run_op(3'd6, 16'h0, 8'h20, 1'b0, 1'b0, 8'h00, s);
        check("R7 jump target wraps", s, 16'h0010);
        set_ptr(0, 16'h7ff0);
        run_op(3'd6, 16'h0, 8'h20, 1'b0, 1'b0, 8'h00, s);
        check("R7 jump target full width", s, 16'h8010);
        run_op(3'd3, 16'h0, 8'h20, 1'b0, 1'b0, 8'h00, s);
        check("R8 table masked to program width", s, 16'h0010);
        set_ptr(0, 16'h1000);
        run_op(3'd3, 16'h0, 8'h05, 1'b0, 1'b0, 8'h00, s);
        check("R8 table in range", s, 16'h1005);
        run_op(3'd4, 16'h0, 8'h05, 1'b0, 1'b0, 8'h00, s);
        check("R9 ext read address", s, 16'h1000);
        run_op(3'd5, 16'h0, 8'hff, 1'b0, 1'b0, 8'h00, s);
        check("R9 ext write address", s, 16'h1000);
        sample_ptr("R9 ptr unchanged by access ops", 16'h1000);
    endtask

    task automatic t_bump();
        logic [7:0] d;
        reg_write(8'h86, 8'h66);
        reg_bump(8'h86);
        read_reg(8'h86, d); check("R10 ctrl bump flips bit 0", {8'd0, d}, 16'h0067);
        reg_bump(8'h86);
        read_reg(8'h86, d); check("R10 ctrl bump back", {8'd0, d}, 16'h0066);
        reg_write(8'h86, 8'h00);
        set_ptr(1, 16'h30ff);
        reg_bump(8'h84);
        read_reg(8'h84, d); check("R10 byte bump wraps", {8'd0, d}, 16'h0000);
        read_reg(8'h85, d); check("R10 no carry to high", {8'd0, d}, 16'h0030);
    endtask

    task automatic t_conflict();
        logic [15:0] s;
        logic [7:0]  d;
        reg_write(8'h86, 8'h20);
        set_ptr(0, 16'h2000);
        run_op(3'd2, 16'h0, 8'h0, 1'b1, 1'b0, 8'h00, s);
        sample_ptr("R11 write blocks step", 16'h2000);
        read_reg(8'h86, d); check("R11 write blocks flip", {8'd0, d}, 16'h0020);
        run_op(3'd1, 16'hbeef, 8'h0, 1'b0, 1'b1, 8'h90, s);
        sample_ptr("R11 increment blocks load", 16'h2000);
        read_reg(8'h86, d); check("R11 increment blocks flip", {8'd0, d}, 16'h0020);
        reg_write(8'h86, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_load();
        t_step();
        t_auto();
        t_addr();
        t_bump();
        t_conflict();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

endmodule